// File: doc/BRIEF.md
# Two-Way Set-Associative Read-Allocate Cache

This block sits between a processor and a slower memory and keeps copies of recently used memory lines. Storage is split into two equal halves (ways), each a direct-mapped array of lines with a stored tag and a valid bit. Every lookup indexes both ways with the same set number and compares both stored tags with the request tag at once. A multiplexer then returns the word from whichever way matched. At the default sizes each way holds 256 lines of 16 bytes, for 8 KB in total, and a 32-bit address splits into a 20-bit tag, an 8-bit set index and 4 offset bits.

A read that misses fetches the whole line from memory in one beat. The line is written into a victim way, and the requested word is returned. An empty way in the set is always used first. When both ways are full, the victim depends on a policy fixed at build time. The least-recently-used policy keeps, per set, the way last touched by a hit or a fill. The round-robin policy keeps, per set, the way last filled. Both take the other way. The random policy takes the low bit of a free-running 16-bit LFSR. Writes always go to memory as single words. A write that hits also updates the cached word, and a write that misses allocates nothing.

The processor side is a valid/ready request stream with one request outstanding. `req_ready` is high only while the block is idle, and a request moves on the cycle both are high. Every accepted request produces exactly one single-cycle `rsp_valid` pulse, which carries the read word for reads and zero for writes. The response cannot be held back, so the processor must take it in that cycle. On the memory side, `mem_req_valid` is held with stable address, data and direction until `mem_req_ready`. A refill arrives as one `mem_rsp_valid` beat carrying the full line.

Top module: `pair_cache`

## Requirements
- R1: Out of reset, `req_ready` is 1, `rsp_valid` is 0, `mem_req_valid` is 0, and every line is invalid, so the first read of any address misses.
- R2: Address bits [1:0] select a byte and are ignored for lookup. Bits [3:2] pick the 32-bit word within the 16-byte line. The next SET_W bits select the set, and the remaining upper bits form the tag.
- R3: A read miss issues one memory read whose address has its low 4 bits cleared. Word i of the returned line sits in bits [32i+31:32i]. The line is stored in the victim way and the requested word is returned.
- R4: A read hit returns the cached word without any memory request.
- R5: Both ways are compared in the same cycle, and at most one way may match a lookup.
- R6: When a set has an invalid way, a fill goes there (way 0 before way 1), whatever the policy.
- R7: Least-recently-used mode: read hits, write hits and fills mark their way as last used in that set, and a fill into a full set replaces the other way.
- R8: Round-robin mode: only fills mark a way in that set, hits leave the mark alone, and a fill into a full set replaces the way not marked.
- R9: Random mode: a full set's victim is bit 0 of a 16-bit LFSR that is never zero and changes every cycle.
- R10: Every write goes to memory as one word with the full request address and data. A write hit updates the cached word. A write miss causes no refill and allocates nothing.
- R11: A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is low while a request is in flight, and each accepted request yields exactly one single-cycle `rsp_valid`.
- R12: While `mem_req_valid` is high and `mem_req_ready` is low, the memory request keeps its address, data and direction unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read word (zero for writes) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 = word write, 0 = line read |
| mem_req_addr | output | ADDR_W | Line-aligned address for reads, full address for writes |
| mem_req_wdata | output | DATA_W | Write word |
| mem_rsp_valid | input | 1 | Refill line valid |
| mem_rsp_line | input | DATA_W*2^WORD_IDX_W | Refill line, word 0 in the low bits |

## Verification
Two things can land in one transaction. A write that hits must update the cached word and also be forwarded to memory. In least-recently-used mode, the same hit also moves the set's replacement mark. The bench provokes this by writing into a set whose ways were both filled by earlier reads. It then checks that exactly one memory write carried the right address and data, and that a read-back returns the new word with no refill. Separately, reads to two ways followed by a third tag show whether a hit in between moves the victim in least-recently-used mode and leaves it alone in round-robin mode. The bench judges this by which of the older tags misses afterwards.

// File: rtl/pc_pkg.sv
package pc_pkg;

  // Victim policy picked at build time
  typedef enum logic [1:0] {
    REPL_RANDOM = 2'd0,
    REPL_LRU    = 2'd1,
    REPL_ROUND  = 2'd2
  } repl_e;

  // Controller states
  typedef enum logic [2:0] {
    PC_IDLE      = 3'd0,
    PC_LOOK      = 3'd1,
    PC_FILL_REQ  = 3'd2,
    PC_FILL_WAIT = 3'd3,
    PC_WR_MEM    = 3'd4
  } pc_state_e;

  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

endpackage

// File: rtl/pc_way.sv
// One direct-mapped half: valid bits, tag store and line store for every set.
module pc_way #(
  parameter int SET_W      = 8,
  parameter int TAG_W      = 20,
  parameter int DATA_W     = 32,
  parameter int WORD_IDX_W = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [SET_W-1:0]                   set_idx,
  input  logic [TAG_W-1:0]                   tag,
  output logic                               hit,
  output logic                               valid,
  output logic [(DATA_W<<WORD_IDX_W)-1:0]    line,
  input  logic                               fill_en,
  input  logic [(DATA_W<<WORD_IDX_W)-1:0]    fill_line,
  input  logic                               wr_en,
  input  logic [WORD_IDX_W-1:0]              wr_word_idx,
  input  logic [DATA_W-1:0]                  wr_data
);

  localparam int SETS   = 1 << SET_W;
  localparam int LINE_W = DATA_W << WORD_IDX_W;

  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [LINE_W-1:0] line_mem [SETS];

  // Valid bits are the only reset state; tags and data follow them.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (fill_en) begin
      valid_q[set_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_mem[set_idx]  <= tag;
      line_mem[set_idx] <= fill_line;
    end else if (wr_en) begin
      line_mem[set_idx][wr_word_idx*DATA_W +: DATA_W] <= wr_data;
    end
  end

  assign valid = valid_q[set_idx];
  assign hit   = valid_q[set_idx] && (tag_mem[set_idx] == tag);
  assign line  = line_mem[set_idx];

endmodule

// File: rtl/pc_victim.sv
// Per-set replacement record and victim choice for a pair of ways.
module pc_victim
  import pc_pkg::*;
#(
  parameter int    SET_W  = 8,
  parameter repl_e POLICY = REPL_LRU
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  set_idx,
  input  logic [1:0]        valid_pair,
  input  logic              acc_en,
  input  logic              acc_fill,
  input  logic              acc_way,
  output logic              victim,
  output logic [LFSR_W-1:0] rand_state
);

  localparam int SETS = 1 << SET_W;

  logic [LFSR_W-1:0] lfsr_q;
  logic              pol_pick;

  // Free-running Fibonacci LFSR, taps 16,14,13,11
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= LFSR_SEED;
    end else begin
      lfsr_q <= {lfsr_q[LFSR_W-2:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
    end
  end

  generate
    if (POLICY == REPL_RANDOM) begin : g_rand
      assign pol_pick = lfsr_q[0];
    end else begin : g_mark
      logic [SETS-1:0] mark_q;
      logic            upd;
      if (POLICY == REPL_LRU) begin : g_lru
        // Any access (hit or fill) moves the mark
        assign upd = acc_en;
      end else begin : g_rr
        // Only allocations move the mark
        assign upd = acc_en && acc_fill;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mark_q <= '0;
        end else if (upd) begin
          mark_q[set_idx] <= acc_way;
        end
      end
      assign pol_pick = ~mark_q[set_idx];
    end
  endgenerate

  // Empty ways are filled first, lower way preferred
  always_comb begin
    if (!valid_pair[0]) begin
      victim = 1'b0;
    end else if (!valid_pair[1]) begin
      victim = 1'b1;
    end else begin
      victim = pol_pick;
    end
  end

  assign rand_state = lfsr_q;

endmodule

// File: rtl/pair_cache.sv
// Two-way set-associative read-allocate, write-through cache.
module pair_cache
  import pc_pkg::*;
#(
  parameter int    ADDR_W     = 32,
  parameter int    DATA_W     = 32,
  parameter int    WORD_IDX_W = 2,
  parameter int    SET_W      = 8,
  parameter repl_e POLICY     = REPL_LRU
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic                            req_write,
  input  logic [ADDR_W-1:0]               req_addr,
  input  logic [DATA_W-1:0]               req_wdata,
  output logic                            rsp_valid,
  output logic [DATA_W-1:0]               rsp_rdata,
  output logic                            mem_req_valid,
  input  logic                            mem_req_ready,
  output logic                            mem_req_write,
  output logic [ADDR_W-1:0]               mem_req_addr,
  output logic [DATA_W-1:0]               mem_req_wdata,
  input  logic                            mem_rsp_valid,
  input  logic [(DATA_W<<WORD_IDX_W)-1:0] mem_rsp_line
);

  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int OFF_W  = BYTE_W + WORD_IDX_W;
  localparam int TAG_W  = ADDR_W - OFF_W - SET_W;
  localparam int LINE_W = DATA_W << WORD_IDX_W;
  localparam int NWAYS  = 2;

  pc_state_e state_q, state_d;

  logic                  q_write;
  logic [ADDR_W-1:0]     q_addr;
  logic [DATA_W-1:0]     q_wdata;
  logic                  victim_q;
  logic                  rsp_valid_q;
  logic [DATA_W-1:0]     rsp_rdata_q;

  logic [WORD_IDX_W-1:0] q_word;
  logic [SET_W-1:0]      q_set;
  logic [TAG_W-1:0]      q_tag;

  logic [NWAYS-1:0]      hit_vec;
  logic [NWAYS-1:0]      valid_vec;
  logic [LINE_W-1:0]     way_line [NWAYS];
  logic [NWAYS-1:0]      way_fill_en;
  logic [NWAYS-1:0]      way_wr_en;

  logic                  hit_any;
  logic                  hit_way;
  logic [LINE_W-1:0]     sel_line;
  logic                  victim;
  logic                  acc_en, acc_fill, acc_way;
  logic [LFSR_W-1:0]     rand_state;
  logic                  in_lookup;

  function automatic logic [DATA_W-1:0] pick_word(input logic [LINE_W-1:0] ln,
                                                  input logic [WORD_IDX_W-1:0] idx);
    return ln[idx*DATA_W +: DATA_W];
  endfunction

  // Address fields of the captured request
  assign q_word = q_addr[BYTE_W +: WORD_IDX_W];
  assign q_set  = q_addr[OFF_W +: SET_W];
  assign q_tag  = q_addr[ADDR_W-1 -: TAG_W];

  // Both ways searched in parallel
  generate
    for (genvar w = 0; w < NWAYS; w++) begin : g_way
      pc_way #(
        .SET_W      (SET_W),
        .TAG_W      (TAG_W),
        .DATA_W     (DATA_W),
        .WORD_IDX_W (WORD_IDX_W)
      ) u_way (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_idx     (q_set),
        .tag         (q_tag),
        .hit         (hit_vec[w]),
        .valid       (valid_vec[w]),
        .line        (way_line[w]),
        .fill_en     (way_fill_en[w]),
        .fill_line   (mem_rsp_line),
        .wr_en       (way_wr_en[w]),
        .wr_word_idx (q_word),
        .wr_data     (q_wdata)
      );
    end
  endgenerate

  assign hit_any  = |hit_vec;
  assign hit_way  = hit_vec[1];
  assign sel_line = way_line[hit_way];

  pc_victim #(
    .SET_W  (SET_W),
    .POLICY (POLICY)
  ) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_idx    (q_set),
    .valid_pair (valid_vec),
    .acc_en     (acc_en),
    .acc_fill   (acc_fill),
    .acc_way    (acc_way),
    .victim     (victim),
    .rand_state (rand_state)
  );

  // Next state and per-cycle strobes
  always_comb begin
    state_d     = state_q;
    way_fill_en = '0;
    way_wr_en   = '0;
    acc_en      = 1'b0;
    acc_fill    = 1'b0;
    acc_way     = 1'b0;
    case (state_q)
      PC_IDLE: begin
        if (req_valid) state_d = PC_LOOK;
      end
      PC_LOOK: begin
        if (q_write) begin
          way_wr_en = hit_vec;
          acc_en    = hit_any;
          acc_way   = hit_way;
          state_d   = PC_WR_MEM;
        end else if (hit_any) begin
          acc_en  = 1'b1;
          acc_way = hit_way;
          state_d = PC_IDLE;
        end else begin
          state_d = PC_FILL_REQ;
        end
      end
      PC_FILL_REQ: begin
        if (mem_req_ready) state_d = PC_FILL_WAIT;
      end
      PC_FILL_WAIT: begin
        if (mem_rsp_valid) begin
          way_fill_en[victim_q] = 1'b1;
          acc_en   = 1'b1;
          acc_fill = 1'b1;
          acc_way  = victim_q;
          state_d  = PC_IDLE;
        end
      end
      PC_WR_MEM: begin
        if (mem_req_ready) state_d = PC_IDLE;
      end
      default: state_d = PC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= PC_IDLE;
      q_write     <= 1'b0;
      q_addr      <= '0;
      q_wdata     <= '0;
      victim_q    <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= 1'b0;
      case (state_q)
        PC_IDLE: begin
          if (req_valid) begin
            q_write <= req_write;
            q_addr  <= req_addr;
            q_wdata <= req_wdata;
          end
        end
        PC_LOOK: begin
          victim_q <= victim;
          if (!q_write && hit_any) begin
            rsp_valid_q <= 1'b1;
            rsp_rdata_q <= pick_word(sel_line, q_word);
          end
        end
        PC_FILL_WAIT: begin
          if (mem_rsp_valid) begin
            rsp_valid_q <= 1'b1;
            rsp_rdata_q <= pick_word(mem_rsp_line, q_word);
          end
        end
        PC_WR_MEM: begin
          if (mem_req_ready) begin
            rsp_valid_q <= 1'b1;
            rsp_rdata_q <= '0;
          end
        end
        default: ;
      endcase
    end
  end

  assign req_ready     = (state_q == PC_IDLE);
  assign rsp_valid     = rsp_valid_q;
  assign rsp_rdata     = rsp_rdata_q;
  assign mem_req_valid = (state_q == PC_FILL_REQ) || (state_q == PC_WR_MEM);
  assign mem_req_write = (state_q == PC_WR_MEM);
  assign mem_req_addr  = (state_q == PC_WR_MEM) ? q_addr
                                                : {q_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_req_wdata = q_wdata;
  assign in_lookup     = (state_q == PC_LOOK);

endmodule

// File: rtl/pair_cache_chk.sv
// Property checker attached to every pair_cache instance.
module pair_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [DATA_W-1:0] mem_req_wdata,
  input logic              in_lookup,
  input logic [1:0]        hit_vec,
  input logic [15:0]       rand_state
);

  // R5
  dual_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_lookup |-> ($countones(hit_vec) <= 1));

  // R11
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R11
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)
       && $stable(mem_req_wdata)));

  // R9
  lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rand_state != 16'h0);

  // R9
  lfsr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (rand_state != $past(rand_state)));

endmodule

bind pair_cache pair_cache_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .in_lookup     (in_lookup),
  .hit_vec       (hit_vec),
  .rand_state    (rand_state)
);

// File: tb/pair_cache_bench.sv
// Three instances (random, LRU, round-robin) on a 4-set configuration,
// driven with the same request sequence; each has its own memory model port.
module pair_cache_bench;
  import pc_pkg::*;

  localparam int SW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr  = '0;
  logic [31:0] req_wdata = '0;

  logic [2:0]   req_ready, rsp_valid, mem_req_valid, mem_req_write;
  logic [31:0]  rsp_rdata [3];
  logic [31:0]  mem_req_addr [3];
  logic [31:0]  mem_req_wdata [3];

  // Bench memory: tags 0..3, 4 sets, 4 words
  logic [31:0] bmem [64];

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  function automatic logic [127:0] line_of(input logic [31:0] a);
    int b;
    b = int'(a[7:4]) * 4;
    return {bmem[b+3], bmem[b+2], bmem[b+1], bmem[b]};
  endfunction

  generate
    for (genvar g = 0; g < 3; g++) begin : g_dut
      localparam repl_e P = (g == 0) ? REPL_RANDOM : ((g == 1) ? REPL_LRU : REPL_ROUND);
      logic         rdy_q  = 1'b0;
      logic         rspv_q = 1'b0;
      logic [127:0] line_q = '0;
      int           fill_cnt = 0;
      int           wr_cnt   = 0;
      int           align_bad = 0;
      logic [31:0]  last_wa = '0;
      logic [31:0]  last_wd = '0;

      pair_cache #(.SET_W(SW), .POLICY(P)) u_pair_cache (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready[g]),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .rsp_valid     (rsp_valid[g]),
        .rsp_rdata     (rsp_rdata[g]),
        .mem_req_valid (mem_req_valid[g]),
        .mem_req_ready (rdy_q),
        .mem_req_write (mem_req_write[g]),
        .mem_req_addr  (mem_req_addr[g]),
        .mem_req_wdata (mem_req_wdata[g]),
        .mem_rsp_valid (rspv_q),
        .mem_rsp_line  (line_q)
      );

      // Memory model: ready toggles to create stalls, refill one cycle after accept
      always @(posedge clk) begin
        rdy_q  <= ~rdy_q;
        rspv_q <= 1'b0;
        if (mem_req_valid[g] && rdy_q) begin
          if (mem_req_write[g]) begin
            wr_cnt  <= wr_cnt + 1;
            last_wa <= mem_req_addr[g];
            last_wd <= mem_req_wdata[g];
          end else begin
            fill_cnt <= fill_cnt + 1;
            rspv_q   <= 1'b1;
            line_q   <= line_of(mem_req_addr[g]);
            if (mem_req_addr[g][3:0] != 4'h0) align_bad <= align_bad + 1;
          end
        end
      end
    end
  endgenerate

  function automatic int get_fill(input int i);
    case (i)
      0: return g_dut[0].fill_cnt;
      1: return g_dut[1].fill_cnt;
      default: return g_dut[2].fill_cnt;
    endcase
  endfunction

  function automatic int get_wr(input int i);
    case (i)
      0: return g_dut[0].wr_cnt;
      1: return g_dut[1].wr_cnt;
      default: return g_dut[2].wr_cnt;
    endcase
  endfunction

  function automatic logic [31:0] get_wa(input int i);
    case (i)
      0: return g_dut[0].last_wa;
      1: return g_dut[1].last_wa;
      default: return g_dut[2].last_wa;
    endcase
  endfunction

  function automatic logic [31:0] get_wd(input int i);
    case (i)
      0: return g_dut[0].last_wd;
      1: return g_dut[1].last_wd;
      default: return g_dut[2].last_wd;
    endcase
  endfunction

  function automatic int get_align(input int i);
    case (i)
      0: return g_dut[0].align_bad;
      1: return g_dut[1].align_bad;
      default: return g_dut[2].align_bad;
    endcase
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // One request to all three instances; checks data, refills and write traffic.
  task automatic op(input bit wr, input int tg, input int st, input int wd_i,
                    input logic [1:0] bofs, input logic [31:0] wval,
                    input logic [2:0] exp_fill, input logic [2:0] care, input string rq);
    logic [31:0] a;
    int          f0 [3];
    int          w0 [3];
    logic [31:0] rd [3];
    logic [2:0]  got;
    int          idx;
    a   = (tg << 6) | (st << 4) | (wd_i << 2) | 32'(bofs);
    idx = tg * 16 + st * 4 + wd_i;
    for (int i = 0; i < 3; i++) begin
      f0[i] = get_fill(i);
      w0[i] = get_wr(i);
    end
    @(negedge clk);
    chk(req_ready == 3'b111, "R11 ready when idle", 32'(req_ready), 32'h7);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = wval;
    @(negedge clk);
    req_valid = 1'b0;
    got = '0;
    for (int k = 0; k < 40 && got != 3'b111; k++) begin
      for (int i = 0; i < 3; i++) begin
        if (rsp_valid[i] && !got[i]) begin
          got[i] = 1'b1;
          rd[i]  = rsp_rdata[i];
        end
      end
      if (got != 3'b111) @(negedge clk);
    end
    chk(got == 3'b111, "R11 one response each", 32'(got), 32'h7);
    if (wr) begin
      bmem[idx] = wval;
      for (int i = 0; i < 3; i++) begin
        chk(get_wr(i) - w0[i] == 1, "R10 one memory write", 32'(get_wr(i) - w0[i]), 32'd1);
        chk(get_wa(i) == a, "R10 write address", get_wa(i), a);
        chk(get_wd(i) == wval, "R10 write data", get_wd(i), wval);
        chk(get_fill(i) == f0[i], "R10 no refill on write", 32'(get_fill(i) - f0[i]), 32'd0);
      end
    end else begin
      for (int i = 0; i < 3; i++) begin
        chk(rd[i] == bmem[idx], {rq, " read data"}, rd[i], bmem[idx]);
        if (care[i])
          chk(get_fill(i) - f0[i] == int'(exp_fill[i]), {rq, " refill count"},
              32'(get_fill(i) - f0[i]), 32'(exp_fill[i]));
        chk(get_align(i) == 0, "R3 line-aligned refill", 32'(get_align(i)), 32'd0);
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) bmem[i] = (32'(i) * 32'h01000193) ^ 32'hC0DE0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(req_ready == 3'b111, "R1 req_ready in reset", 32'(req_ready), 32'h7);
    chk(rsp_valid == 3'b000, "R1 rsp_valid in reset", 32'(rsp_valid), 32'h0);
    chk(mem_req_valid == 3'b000, "R1 mem_req_valid in reset", 32'(mem_req_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 3'b111, "R1 req_ready after reset", 32'(req_ready), 32'h7);

    for (int s = 0; s < 4; s++) begin
      // Tag 0: cold miss on word 0 (R1, R3), hits on the rest (R4, R2)
      op(1'b0, 0, s, 0, 2'b00, '0, 3'b111, 3'b111, "R1 R3 cold miss");
      for (int w = 1; w < 4; w++)
        op(1'b0, 0, s, w, 2'b00, '0, 3'b000, 3'b111, "R4 R2 hit word");
      op(1'b0, 0, s, 1, 2'b11, '0, 3'b000, 3'b111, "R2 byte offset ignored");
      // Tag 1 goes to the empty way, both stay resident (R6, R5)
      op(1'b0, 1, s, 2, 2'b00, '0, 3'b111, 3'b111, "R3 second tag miss");
      op(1'b0, 0, s, 1, 2'b00, '0, 3'b000, 3'b111, "R6 R5 tag0 kept");
      op(1'b0, 1, s, 3, 2'b00, '0, 3'b000, 3'b111, "R6 R5 tag1 kept");
      // Touch tag 0, then tag 2 evicts: LRU drops tag 1, round-robin drops tag 0
      op(1'b0, 0, s, 0, 2'b00, '0, 3'b000, 3'b111, "R7 R8 touch tag0");
      op(1'b0, 2, s, 0, 2'b00, '0, 3'b111, 3'b111, "R9 R3 third tag miss");
      op(1'b0, 0, s, 2, 2'b00, '0, 3'b100, 3'b110, "R7 R8 victim choice");
      op(1'b0, 1, s, 0, 2'b00, '0, 3'b110, 3'b110, "R7 R8 evicted tag1");
      // Write hit updates cache and memory; write miss allocates nothing (R10)
      op(1'b1, 0, s, 3, 2'b00, 32'hA5000000 | 32'(s << 8), '0, '0, "R10");
      op(1'b0, 0, s, 3, 2'b00, '0, 3'b000, 3'b110, "R10 write-hit readback");
      op(1'b1, 3, s, 1, 2'b00, 32'h5A000000 | 32'(s << 4), '0, '0, "R10");
      op(1'b0, 3, s, 1, 2'b00, '0, 3'b111, 3'b111, "R10 write-miss not allocated");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R11 watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule